// File: doc/BRIEF.md
# Sleep-Aware Successive-Approximation Conversion Controller

This block sequences an 8-bit successive-approximation A/D conversion for a small microcontroller. Software enables the module and pulses a start request. The controller then runs one acquisition period followed by eight bit decisions, MSB first. At each decision it presents a trial code to the external DAC and reads back the external comparator. When the last decision is made, it writes the result register, drops its busy indication and raises a completion flag.

The conversion clock comes from one of two places. It is either the instruction-cycle tick divided by 2, 8 or 32, or a free-running internal RC tick. The choice decides what happens when the core goes to sleep. On the RC source the conversion runs on through sleep. At completion it either requests a wake-up or, when the interrupt is disabled, powers the converter down. On a divided source, sleep kills the conversion outright. In every power-down case the enable input stays as software left it, and only the powered indication falls. A reset also powers the converter off and leaves the result register unwritten.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy (go_o), the completion flag and wake_o are 0, and powered_o is 0 until the next accepted start.
- R2: A start pulse while en_i is 0 is ignored: go_o stays 0 and powered_o stays 0.
- R3: A conversion takes one acquisition period and then 8 decision periods, MSB first. During the decision for bit i, dac_code_o holds the bits already decided plus bit i set. Bit i keeps cmp_i (1 = input at or above the trial code). At the end of the last decision, result_o takes the code, go_o clears and flag_o sets.
- R4: With clk_sel_i = 2'b11 (RC), an accepted start first waits for one icyc_tick_i. RC ticks during that wait are not counted. Afterwards each rc_tick_i is one conversion period.
- R5: clk_sel_i values 2'b00, 2'b01 and 2'b10 make one conversion period from 2, 8 and 32 icyc_tick_i pulses respectively, so a conversion ends on the 18th, 72nd or 288th pulse.
- R6: On RC, sleep_i does not disturb a conversion. If it completes while sleep_i=1 and int_en_i=1, wake_o pulses high for one cycle, and powered_o stays 1.
- R7: If a conversion completes while sleep_i=1 and int_en_i=0, powered_o drops to 0 and no wake occurs. The flag and the result still update.
- R8: sleep_i=1 with a non-RC source and en_i=1 aborts any running conversion and drops powered_o. go_o clears, while result_o and flag_o keep their old values.
- R9: If the abort condition of R8 falls in the same cycle as the final decision, the abort wins and result_o and flag_o are unchanged.
- R10: flag_clr_i clears the flag. If it coincides with a completion, the flag ends up set.
- R11: Dropping en_i aborts a running conversion (go_o clears next cycle). An accepted start powers the converter back up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Module enable bit |
| go_set_i | input | 1 | Start request pulse |
| clk_sel_i | input | 2 | Conversion clock source select |
| sleep_i | input | 1 | Core is in sleep |
| int_en_i | input | 1 | Completion interrupt enable |
| flag_clr_i | input | 1 | Clear the completion flag |
| rc_tick_i | input | 1 | Internal RC clock tick |
| icyc_tick_i | input | 1 | Instruction-cycle tick |
| cmp_i | input | 1 | Comparator: input >= trial code |
| dac_code_o | output | 8 | Trial code to the DAC |
| go_o | output | 1 | Start/busy readback |
| result_o | output | 8 | Conversion result register |
| flag_o | output | 1 | Completion interrupt flag |
| wake_o | output | 1 | Wake-up request pulse |
| powered_o | output | 1 | Converter powered indication |

## Verification
The critical overlap is a sleep-driven abort landing in the same cycle as the final bit decision on a divided clock source. The bench provokes it by counting icyc_tick_i pulses exactly. It raises sleep_i together with the 18th pulse on the divide-by-2 source. It then judges that result_o still holds the previous conversion and that the flag stays clear, with go_o low and powered_o low. A second overlap, flag clear against completion, is driven on the final RC tick and must leave the flag set.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACQ, ST_CONV} adc_state_e;
  localparam logic [1:0] SEL_RC = 2'b11;
endpackage

// File: rtl/adc_conv_clk.sv
module adc_conv_clk #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [1:0] sel_i,
  input  logic       icyc_tick_i,
  input  logic       rc_tick_i,
  output logic       tick_o
);
  localparam int CNT_W = $clog2(DIV_C);

  logic [CNT_W-1:0] cnt_q, lim;

  always_comb begin
    unique case (sel_i)
      2'b00:   lim = CNT_W'(DIV_A - 1);
      2'b01:   lim = CNT_W'(DIV_B - 1);
      default: lim = CNT_W'(DIV_C - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (restart_i)   cnt_q <= '0;
    else if (icyc_tick_i) cnt_q <= (cnt_q >= lim) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = (sel_i == adc_seq_pkg::SEL_RC) ? rc_tick_i
                                                 : (icyc_tick_i && cnt_q >= lim);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] next_o,
  output logic             last_o
);
  localparam int IDX_W = $clog2(RES_W);

  logic [RES_W-1:0] value_q, bit_sel;
  logic [IDX_W-1:0] idx_q;

  assign bit_sel = RES_W'(1) << idx_q;
  assign trial_o = value_q | bit_sel;
  assign next_o  = (value_q & ~bit_sel) | (cmp_i ? bit_sel : '0);
  assign last_o  = (idx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q <= '0;
      idx_q   <= IDX_W'(RES_W - 1);
    end else if (load_i) begin
      value_q <= '0;
      idx_q   <= IDX_W'(RES_W - 1);
    end else if (step_i) begin
      value_q <= next_o;
      if (!last_o) idx_q <= idx_q - 1'b1;
    end
  end

  // R3: a fresh conversion trials the MSB alone
  assert_msb_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> trial_o == (RES_W'(1) << (RES_W - 1)));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 8,
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             go_set_i,
  input  logic [1:0]       clk_sel_i,
  input  logic             sleep_i,
  input  logic             int_en_i,
  input  logic             flag_clr_i,
  input  logic             rc_tick_i,
  input  logic             icyc_tick_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic             go_o,
  output logic [RES_W-1:0] result_o,
  output logic             flag_o,
  output logic             wake_o,
  output logic             powered_o
);
  adc_state_e       state_q, state_d;
  logic             rc_sel, busy, accept, sleep_kill, abort;
  logic             conv_tick, restart, step, last, complete;
  logic             off_q, flag_q, wake_q;
  logic [RES_W-1:0] next_code, result_q;

  assign rc_sel     = (clk_sel_i == SEL_RC);
  assign busy       = (state_q != ST_IDLE);
  assign accept     = go_set_i & en_i & ~busy;
  assign sleep_kill = en_i & sleep_i & ~rc_sel;
  assign abort      = busy & (~en_i | sleep_kill);
  assign restart    = accept | (state_q == ST_WAIT && icyc_tick_i);
  assign step       = (state_q == ST_CONV) & conv_tick & ~abort;
  assign complete   = step & last;

  adc_conv_clk #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clk (
    .clk_i, .rst_ni, .restart_i(restart), .sel_i(clk_sel_i),
    .icyc_tick_i, .rc_tick_i, .tick_o(conv_tick)
  );

  adc_sar_core #(.RES_W(RES_W)) u_sar (
    .clk_i, .rst_ni, .load_i(accept), .step_i(step), .cmp_i,
    .trial_o(dac_code_o), .next_o(next_code), .last_o(last)
  );

  always_comb begin
    state_d = state_q;
    if (abort) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE: if (accept) state_d = rc_sel ? ST_WAIT : ST_ACQ;
        ST_WAIT: if (icyc_tick_i) state_d = ST_ACQ;
        ST_ACQ:  if (conv_tick) state_d = ST_CONV;
        ST_CONV: if (complete) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      off_q   <= 1'b1;
      flag_q  <= 1'b0;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= complete & sleep_i & int_en_i;
      if (complete)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      if (sleep_kill)                              off_q <= 1'b1;
      else if (complete & sleep_i & ~int_en_i)     off_q <= 1'b1;
      else if (accept)                             off_q <= 1'b0;
    end
  end

  // result register has no reset: contents undefined after power-on
  always_ff @(posedge clk_i) begin
    if (complete) result_q <= next_code;
  end

  assign go_o      = busy;
  assign result_o  = result_q;
  assign flag_o    = flag_q;
  assign wake_o    = wake_q;
  assign powered_o = en_i & ~off_q;

  assert_disabled_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !go_o);
  assert_sleep_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && en_i && sleep_i && !rc_sel) |=> (!go_o && !powered_o && $stable(flag_o)));
  assert_result_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !complete |=> $stable(result_o));
  assert_wake_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(sleep_i && int_en_i && go_o));
  assert_rc_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && rc_sel) |=> state_q == ST_WAIT);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       en = 0, go_set = 0, sleep = 0, int_en = 0, flag_clr = 0;
  logic       rc_tick = 0, icyc = 0;
  logic [1:0] sel = 2'b11;
  logic [7:0] vin = 8'h00;
  logic [7:0] dac, result;
  logic       go, flag, wake, powered, cmp;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;
  assign cmp = (vin >= dac);

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .go_set_i(go_set), .clk_sel_i(sel),
    .sleep_i(sleep), .int_en_i(int_en), .flag_clr_i(flag_clr), .rc_tick_i(rc_tick),
    .icyc_tick_i(icyc), .cmp_i(cmp), .dac_code_o(dac), .go_o(go), .result_o(result),
    .flag_o(flag), .wake_o(wake), .powered_o(powered)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic start();
    go_set = 1; cyc(); go_set = 0;
  endtask

  task automatic rc_pulse();
    rc_tick = 1; cyc(); rc_tick = 0;
  endtask

  // RC conversion; checks trial codes (R3); leaves final pulse to caller
  task automatic rc_until_last();
    logic [7:0] exp_trial;
    sel = 2'b11; start();
    icyc = 1; cyc(); icyc = 0;
    rc_pulse();
    for (int i = 7; i >= 0; i--) begin
      exp_trial = (vin & ~((8'd1 << (i + 1)) - 8'd1)) | (8'd1 << i);
      if (i == 7) exp_trial = 8'h80;
      check("R3 trial", dac, exp_trial);
      if (i > 0) rc_pulse();
    end
  endtask

  task automatic t_reset();
    check("R1 go", go, 0); check("R1 flag", flag, 0);
    check("R1 wake", wake, 0); check("R1 powered", powered, 0);
  endtask

  task automatic t_disabled_start();
    en = 0; start(); cyc();
    check("R2 go", go, 0); check("R2 powered", powered, 0);
  endtask

  task automatic t_rc_basic();
    en = 1; vin = 8'hA5;
    rc_until_last(); rc_pulse();
    check("R3 result", result, 8'hA5); check("R3 go", go, 0); check("R3 flag", flag, 1);
    flag_clr = 1; cyc(); flag_clr = 0;
    check("R10 cleared", flag, 0);
  endtask

  task automatic t_rc_wait();
    vin = 8'h3C; sel = 2'b11; start();
    rc_pulse(); // during wait: must not count
    icyc = 1; cyc(); icyc = 0;
    for (int i = 0; i < 8; i++) rc_pulse();
    check("R4 still busy", go, 1);
    rc_pulse();
    check("R4 done", go, 0); check("R4 result", result, 8'h3C);
  endtask

  task automatic t_div(logic [1:0] s, int n, logic [7:0] v, string tag);
    vin = v; sel = s; start();
    icyc = 1;
    repeat (9 * n - 1) cyc();
    icyc = 0;
    check({tag, " busy"}, go, 1);
    icyc = 1; cyc(); icyc = 0;
    check({tag, " done"}, go, 0); check({tag, " result"}, result, v);
  endtask

  task automatic t_sleep_wake();
    vin = 8'h5A; int_en = 1;
    rc_until_last(); sleep = 1; rc_pulse();
    check("R6 result", result, 8'h5A); check("R6 wake", wake, 1);
    check("R6 powered", powered, 1);
    cyc(); check("R6 wake pulse", wake, 0);
    sleep = 0; int_en = 0; flag_clr = 1; cyc(); flag_clr = 0;
  endtask

  task automatic t_sleep_off();
    vin = 8'h81; int_en = 0;
    rc_until_last(); sleep = 1; rc_pulse();
    check("R7 result", result, 8'h81); check("R7 flag", flag, 1);
    check("R7 powered", powered, 0); check("R7 wake", wake, 0);
    sleep = 0; flag_clr = 1; cyc(); flag_clr = 0;
    start(); check("R11 repowered", powered, 1);
    en = 0; cyc(); en = 1; check("R11 aborted", go, 0);
  endtask

  task automatic t_sleep_abort();
    vin = 8'hFF; sel = 2'b00; start();
    icyc = 1; repeat (7) cyc(); icyc = 0;
    sleep = 1; cyc(); sleep = 0;
    check("R8 go", go, 0); check("R8 powered", powered, 0);
    check("R8 result", result, 8'h81); check("R8 flag", flag, 0);
  endtask

  task automatic t_collide();
    vin = 8'h12; sel = 2'b00; start();
    icyc = 1; repeat (17) cyc();
    sleep = 1; cyc(); sleep = 0; icyc = 0;
    check("R9 go", go, 0); check("R9 result", result, 8'h81);
    check("R9 flag", flag, 0); check("R9 powered", powered, 0);
  endtask

  task automatic t_clr_collide();
    vin = 8'h07;
    rc_until_last(); flag_clr = 1; rc_pulse(); flag_clr = 0;
    check("R10 set wins", flag, 1); check("R10 result", result, 8'h07);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    t_reset();
    t_disabled_start();
    t_rc_basic();
    t_rc_wait();
    t_div(2'b00, 2, 8'h9E, "R5 div2");
    t_div(2'b01, 8, 8'h01, "R5 div8");
    t_div(2'b10, 32, 8'hFE, "R5 div32");
    t_sleep_wake();
    t_sleep_off();
    t_sleep_abort();
    t_collide();
    t_clr_collide();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule